// File: doc/BRIEF.md
# Key-Scan Host Register Target (I2C)

This block is the host-facing side of a matrix key-scan controller. It is an I2C target that works from a fast system clock, samples the bus lines through synchronizers, and carries the protocol down to a single configuration register and a read-only key status byte. The host writes the configuration over the bus. It fetches debounced key events by reading the status byte, which the event queue supplies.

A transfer starts with START, then an address byte. The address is the fixed prefix `10110` followed by the two strap pins, with the read/write flag in the last position. A command byte then selects the register. A write follows that with one data byte. A read uses a repeated START and the address again with the read flag set. The target then returns the selected register.

Each status byte that the target shifts out produces one pop strobe towards the event queue, so the next byte read returns the next event. A separate active-low bus reset drops any transfer in progress and leaves the register contents unchanged. SDA is modelled as a pull-low enable plus a sampled input line.

Top module: `kscan_i2c_target`

## Requirements
- R1: The target answers only to the address whose upper five bits are `10110` and whose next two bits equal `dev_sel[1:0]`, bit 0 being the read (1) / write (0) flag. It acknowledges that address by pulling SDA low during the ninth clock. For any other address it leaves SDA released for the rest of the transfer.
- R2: Bytes travel most significant bit first. Each byte the target receives (address, command, data) is acknowledged by holding SDA low while SCL is high in the ninth clock.
- R3: A write with command `08h` stores the data byte verbatim (all 8 bits) in the configuration register, which appears on `cfg_o`.
- R4: After system reset `cfg_o` is `10h`, SDA is released and no pop strobe has occurred.
- R5: A read (command write, repeated START, address with read flag) returns the selected register MSB first; command `08h` returns the configuration value.
- R6: Reading command `10h` returns `status_i`. Each status byte produces exactly one single-cycle `pop_o` pulse after its eighth bit has been shifted out. Reads of `08h` never pulse `pop_o`.
- R7: Writes to `10h` or to any command other than `08h` are acknowledged and leave `cfg_o` unchanged. Reads of any command other than `08h` and `10h` return `00h` without a pop.
- R8: When the master NACKs a read byte, the target returns to idle and drives SDA no more until the next START.
- R9: When the master ACKs a read byte, the target sends another byte of the same register; for `10h` that is the next queued event.
- R10: While `bus_rst_n` is low the target releases SDA and drops the transfer. Bits that follow are ignored until a new START, and `cfg_o` is unchanged.
- R11: A STOP at any point ends the transfer. A partly received data byte is discarded, and the next transfer works normally.
- R12: The target changes its SDA drive only while SCL is low, apart from the release forced by `bus_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_rst_n | input | 1 | Active-low bus reset; aborts the current transfer |
| dev_sel | input | 2 | Strap pins forming the two low address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| status_i | input | 8 | Head of the key event queue |
| pop_o | output | 1 | One-cycle strobe: the status byte has been delivered |
| cfg_o | output | 8 | Configuration register contents |

## Verification
The bench sweeps all 128 seven-bit addresses against one strap setting and tries every strap setting for a match. A decoder that mis-ordered the pins or ignored a prefix bit would then acknowledge a foreign address or stay silent on its own. Configuration values are written and read back across the byte range, so a bit reversal or a dropped bit shows as a readback mismatch. Multi-byte status reads are checked against a bench event queue. A missing or doubled pop would then return the wrong event and give the wrong pop count, and a pop on a configuration read or an unknown register would show the same way. Aborts by STOP and by bus reset in the middle of a byte, and a NACK followed by extra clocks, target a state machine that would otherwise finish the byte, corrupt the configuration or keep driving the line.

// File: rtl/kscan_i2c_pkg.sv
package kscan_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [4:0]        ADDR_PREFIX = 5'b10110;
    localparam logic [BYTE_W-1:0] REG_CFG     = 8'h08;
    localparam logic [BYTE_W-1:0] REG_STAT    = 8'h10;
    localparam logic [BYTE_W-1:0] CFG_RESET   = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK,
        ST_READ,
        ST_MACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e        state;
        bus_state_e        after;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              pop;
        logic              wr_en;
        logic              nack;
    } proto_regs_t;

endpackage

// File: rtl/kscan_i2c_sync.sv
module kscan_i2c_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] pipe_q [WIDTH];
    logic [STAGES-1:0] pipe_d [WIDTH];
    logic [WIDTH-1:0]  prev_q;
    logic [WIDTH-1:0]  prev_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        always_comb begin
            pipe_d[g] = {pipe_q[g][STAGES-2:0], din[g]};
            prev_d[g] = pipe_q[g][TOP];
            level[g]  = pipe_q[g][TOP];
            rise[g]   = pipe_q[g][TOP] & ~prev_q[g];
            fall[g]   = ~pipe_q[g][TOP] & prev_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[g] <= '1;
                prev_q[g] <= 1'b1;
            end else begin
                pipe_q[g] <= pipe_d[g];
                prev_q[g] <= prev_d[g];
            end
        end
    end

endmodule

// File: rtl/kscan_i2c_regs.sv
module kscan_i2c_regs
    import kscan_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] status_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] cfg_o
);

    logic [BYTE_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && ptr == REG_CFG) cfg_d = wr_data;
        unique case (ptr)
            REG_CFG:  rd_data = cfg_q;
            REG_STAT: rd_data = status_i;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R3 R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/kscan_i2c_proto.sv
module kscan_i2c_proto
    import kscan_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic [1:0]        dev_sel,
    input  logic              scl_h,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_h,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr,
    output logic              pop
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    proto_regs_t q, d;
    logic        start_det, stop_det, addr_hit;

    assign start_det = sda_fall & scl_h;
    assign stop_det  = sda_rise & scl_h;
    assign addr_hit  = (q.shreg[BYTE_W-1:1] == {ADDR_PREFIX, dev_sel});

    always_comb begin
        d       = q;
        d.pop   = 1'b0;
        d.wr_en = 1'b0;
        if (!bus_rst_n || stop_det) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (start_det) begin
            d.state = ST_ADDR;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && q.cnt != FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_h};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.state = ST_ACK;
                        unique case (q.state)
                            ST_ADDR: begin
                                if (addr_hit) begin
                                    d.after = q.shreg[0] ? ST_READ : ST_CMD;
                                end else begin
                                    d.state = ST_IDLE;
                                    d.oe    = 1'b0;
                                end
                            end
                            ST_CMD: begin
                                d.ptr   = q.shreg;
                                d.after = ST_WDATA;
                            end
                            default: begin
                                d.wr_en = 1'b1;
                                d.after = ST_WDATA;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.state = q.after;
                        if (q.after == ST_READ) begin
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[BYTE_W-1];
                            d.cnt   = CNT_W'(1);
                        end else begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                        end
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (q.cnt == FULL) begin
                            d.oe    = 1'b0;
                            d.state = ST_MACK;
                            d.pop   = (q.ptr == REG_STAT);
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shreg[BYTE_W-2];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.nack = sda_h;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_READ;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[BYTE_W-1];
                            d.cnt   = CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.after <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_data = q.shreg;
    assign ptr     = q.ptr;
    assign pop     = q.pop;

    // R12
    oe_set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_h);

    // R12
    oe_clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.oe) && $past(bus_rst_n)) |-> !scl_h);

    // R6
    pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pop |=> !q.pop);

    // R6
    pop_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pop |-> (q.state == ST_MACK && q.ptr == REG_STAT));

    // R10
    bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (!q.oe && q.state == ST_IDLE));

endmodule

// File: rtl/kscan_i2c_target.sv
module kscan_i2c_target
    import kscan_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic [1:0]        dev_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [BYTE_W-1:0] status_i,
    output logic              pop_o,
    output logic [BYTE_W-1:0] cfg_o
);

    logic [1:0]        lvl, rse, fll;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, ptr, rd_data;

    kscan_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .level (lvl),
        .rise  (rse),
        .fall  (fll)
    );

    kscan_i2c_proto u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_n (bus_rst_n),
        .dev_sel   (dev_sel),
        .scl_h     (lvl[1]),
        .scl_rise  (rse[1]),
        .scl_fall  (fll[1]),
        .sda_h     (lvl[0]),
        .sda_rise  (rse[0]),
        .sda_fall  (fll[0]),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .pop       (pop_o)
    );

    kscan_i2c_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .ptr      (ptr),
        .wr_data  (wr_data),
        .status_i (status_i),
        .rd_data  (rd_data),
        .cfg_o    (cfg_o)
    );

endmodule

// File: tb/tb_kscan_i2c_target.sv
`timescale 1ns/1ps
module tb_kscan_i2c_target;

    localparam int Q = 6;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_rst_n = 1;
    logic [1:0] dev_sel = 2'b00;
    logic       scl = 1, sda_m = 1;
    logic       sda_oe, pop;
    logic [7:0] cfg, status;
    logic       sda_bus;
    int         pops = 0;
    int         n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign status  = 8'((pops * 37 + 5) & 255);

    always @(posedge clk) begin
        if (!rst_n) pops <= 0;
        else if (pop) pops <= pops + 1;
    end

    kscan_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .dev_sel(dev_sel),
        .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .status_i(status), .pop_o(pop), .cfg_o(cfg)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; tick; scl = 1; tick; sda_m = 0; tick; scl = 0; tick;
    endtask

    task automatic bus_stop;
        sda_m = 0; tick; scl = 1; tick; sda_m = 1; tick;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick; scl = 1; tick; tick; scl = 0; tick;
        end
    endtask

    task automatic ack_clock(output logic acked);
        sda_m = 1; tick; scl = 1; tick; acked = (sda_bus == 1'b0); tick; scl = 0; tick;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        ack_clock(acked);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1; tick; scl = 1; tick; b = {b[6:0], sda_bus}; tick; scl = 0; tick;
        end
        sda_m = m_ack ? 1'b0 : 1'b1; tick; scl = 1; tick; tick; scl = 0; tick;
        sda_m = 1;
    endtask

    function automatic logic [7:0] dev_addr(input logic rw);
        return {5'b10110, dev_sel, rw};
    endfunction

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val, output int acks);
        logic a;
        acks = 0;
        bus_start;
        send_byte(dev_addr(1'b0), a); acks += int'(a);
        send_byte(cmd, a);            acks += int'(a);
        send_byte(val, a);            acks += int'(a);
        bus_stop;
    endtask

    task automatic read_reg(input logic [7:0] cmd, input int nb, output logic [7:0] got [3], output int acks);
        logic a;
        acks = 0;
        bus_start;
        send_byte(dev_addr(1'b0), a); acks += int'(a);
        send_byte(cmd, a);            acks += int'(a);
        bus_start;
        send_byte(dev_addr(1'b1), a); acks += int'(a);
        for (int k = 0; k < nb; k++) recv_byte(k != nb - 1, got[k]);
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got [3];
        logic       a;
        int         acks, base;

        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R4 reset state
        chk("R4 cfg", cfg, 8'h10);
        chk("R4 oe", sda_oe, 0);
        chk("R4 pops", pops, 0);

        // R1 every strap value matches its own address
        for (int p = 0; p < 4; p++) begin
            dev_sel = 2'(p);
            write_reg(8'h08, 8'(8'h40 + p), acks);
            chk("R1 strap acks", acks, 3);
            chk("R1 strap cfg", cfg, 8'h40 + p);
        end

        // R1 exhaustive address sweep with strap 2
        dev_sel = 2'b10;
        for (int adr = 0; adr < 128; adr++) begin
            bus_start;
            send_byte({7'(adr), 1'b0}, a);
            bus_stop;
            chk("R1 addr decode", a, (adr == 7'b1011010) ? 1 : 0);
        end

        // R2 R3 R5 configuration write and readback sweep
        for (int v = 0; v < 256; v += 17) begin
            write_reg(8'h08, 8'(v), acks);
            chk("R2 write acks", acks, 3);
            chk("R3 cfg_o", cfg, v);
            read_reg(8'h08, 1, got, acks);
            chk("R5 readback", got[0], v);
        end
        write_reg(8'h08, 8'h01, acks);
        read_reg(8'h08, 1, got, acks);
        chk("R2 lsb only", got[0], 8'h01);
        write_reg(8'h08, 8'h80, acks);
        read_reg(8'h08, 1, got, acks);
        chk("R2 msb only", got[0], 8'h80);

        // R6 R9 status reads pop one event per byte
        for (int nb = 1; nb <= 3; nb++) begin
            base = pops;
            read_reg(8'h10, nb, got, acks);
            chk("R6 read acks", acks, 3);
            for (int k = 0; k < nb; k++)
                chk("R9 event byte", got[k], ((base + k) * 37 + 5) & 255);
            chk("R6 pop count", pops - base, nb);
        end

        // R6 configuration read never pops
        base = pops;
        read_reg(8'h08, 2, got, acks);
        chk("R9 cfg repeat", got[1], 8'h80);
        chk("R6 no pop cfg", pops - base, 0);

        // R7 unknown reads are zero, writes elsewhere ignored
        for (int u = 0; u < 6; u++) begin
            logic [7:0] cmd;
            cmd = (u == 0) ? 8'h00 : (u == 1) ? 8'h07 : (u == 2) ? 8'h09 :
                  (u == 3) ? 8'h0F : (u == 4) ? 8'h11 : 8'hFF;
            base = pops;
            read_reg(cmd, 1, got, acks);
            chk("R7 unknown read", got[0], 0);
            chk("R7 unknown no pop", pops - base, 0);
            write_reg(cmd, 8'h5A, acks);
            chk("R7 write acked", acks, 3);
            chk("R7 cfg kept", cfg, 8'h80);
        end
        write_reg(8'h10, 8'h33, acks);
        chk("R7 status write acks", acks, 3);
        chk("R7 status write ignored", cfg, 8'h80);

        // R8 NACK returns to idle, extra clocks see a released line
        read_reg(8'h08, 1, got, acks);
        base = pops;
        recv_byte(1'b0, got[1]);
        chk("R8 released after nack", got[1], 8'hFF);
        chk("R8 no pop", pops - base, 0);

        // R11 STOP in the middle of a data byte
        bus_start;
        send_byte(dev_addr(1'b0), a);
        send_byte(8'h08, a);
        send_bits(8'h3C, 4);
        bus_stop;
        chk("R11 partial dropped", cfg, 8'h80);
        write_reg(8'h08, 8'h2B, acks);
        chk("R11 recovery acks", acks, 3);
        chk("R11 recovery cfg", cfg, 8'h2B);

        // R10 bus reset in the middle of a write
        bus_start;
        send_byte(dev_addr(1'b0), a);
        send_byte(8'h08, a);
        send_bits(8'hC3, 4);
        bus_rst_n = 0; repeat (4) @(negedge clk); bus_rst_n = 1;
        send_bits(8'h03, 4);
        ack_clock(a);
        chk("R10 no ack after abort", a, 0);
        bus_stop;
        chk("R10 cfg kept", cfg, 8'h2B);

        // R10 bus reset while the target drives read data
        write_reg(8'h08, 8'h00, acks);
        bus_start;
        send_byte(dev_addr(1'b0), a);
        send_byte(8'h08, a);
        bus_start;
        send_byte(dev_addr(1'b1), a);
        repeat (3) @(negedge clk);
        chk("R10 driving before abort", sda_oe, 1);
        bus_rst_n = 0; repeat (4) @(negedge clk);
        chk("R10 released", sda_oe, 0);
        bus_rst_n = 1;
        recv_byte(1'b0, got[0]);
        chk("R10 stays released", got[0], 8'hFF);
        bus_stop;
        chk("R10 cfg after read abort", cfg, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule